// File: doc/BRIEF.md
# Board Control Register Block

A small word-addressed control peripheral that sits on a simple 32-bit register bus with an address, separate read and write strobes, write data and registered read data. Software reads a fixed build identifier and the processor clock rate, drives a bank of LEDs through a read/write register, and reads the state of a bank of DIP switches that are brought into the clock domain through a synchronizer.

The block also offers a guarded software reset. A full-word write of one exact magic value to a dedicated write-only register makes the block emit a one-cycle board reset request on the following clock edge. Any other value written there does nothing. The decode covers a 64 KiB window. Only word-aligned access is supported, so the two lowest address bits are ignored.

Top module: `board_ctl_regs`

## Requirements
- R1: A read of byte offset 0x0 returns the build identifier parameter, 0x09272011 by default; writes there have no effect.
- R2: A read of offset 0x4 returns the clock frequency parameter in Hz (10,000,000 = 0x00989680 by default); writes there have no effect.
- R3: Offset 0x8 is the LED register: a write stores the low LED_W bits of the write data into `led_o` on the clock edge of the write (1 = LED on), and a read returns that value zero-extended.
- R4: Offset 0xC returns the switch inputs after a two-flop synchronizer (1 = switch on); a read issued two or more cycles after `sw_i` settles returns the new value.
- R5: A write of exactly 0x0000DEAD to offset 0x10 raises `board_rst_req` for the one cycle after the write edge; a write of any other value there leaves it low, and a read of 0x10 returns zero.
- R6: `board_rst_req` is never high in two consecutive cycles, even for back-to-back magic writes.
- R7: A read of any offset other than 0x0, 0x4, 0x8, 0xC returns zero, and writes to undecoded or read-only offsets leave `led_o` unchanged.
- R8: Read data is registered: `bus_rdata` shows the addressed value in the cycle after the read strobe and is zero after any cycle without a read strobe.
- R9: Only address bits [15:2] are decoded; address bits [1:0] are ignored, so 0x0B reads the LED register.
- R10: While reset is asserted, `led_o`, `bus_rdata` and `board_rst_req` are zero.
- R11: When read and write strobes to the LED register fall in the same cycle, the read returns the value held before the write and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (16) | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sw_i | input | SW_W (8) | Asynchronous switch inputs |
| led_o | output | LED_W (8) | LED drive, 1 = on |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The two functions that can meet in one cycle are the registered read and the LED write, when both strobes address offset 0x8 together. The bench loads a known LED pattern, then raises both strobes in a single cycle with a new pattern, and judges that the read data of the next cycle holds the old pattern while `led_o` already holds the new one. A second collision, back-to-back magic writes, is judged by the reset request appearing once and then staying low for the following cycle.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

   // word indices (byte offset / 4); software depends on these positions
   localparam int unsigned WIDX_ID   = 0;
   localparam int unsigned WIDX_FREQ = 1;
   localparam int unsigned WIDX_LED  = 2;
   localparam int unsigned WIDX_SW   = 3;
   localparam int unsigned WIDX_RST  = 4;

   typedef struct packed {
      logic id;
      logic freq;
      logic led;
      logic sw;
      logic rst;
   } bctl_sel_t;

endpackage

// File: rtl/bctl_decode.sv
module bctl_decode
   import board_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output bctl_sel_t         sel
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_lsb;

   assign word       = addr[ADDR_W-1:2];
   assign unused_lsb = addr[1:0];

   always_comb begin
      sel      = '0;
      sel.id   = (word == WORD_W'(WIDX_ID));
      sel.freq = (word == WORD_W'(WIDX_FREQ));
      sel.led  = (word == WORD_W'(WIDX_LED));
      sel.sw   = (word == WORD_W'(WIDX_SW));
      sel.rst  = (word == WORD_W'(WIDX_RST));
   end
endmodule

// File: rtl/bctl_sync.sv
module bctl_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bctl_rst_gate.sv
module bctl_rst_gate #(
   parameter int unsigned DATA_W = 32,
   parameter logic [31:0] MAGIC  = 32'h0000_DEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              req
);
   logic match;
   assign match = wr_hit && (wdata == DATA_W'(MAGIC));

   // suppress a second pulse directly after the first
   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= match && !req;
   end
endmodule

// File: rtl/bctl_rdmux.sv
module bctl_rdmux
   import board_ctl_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LED_W    = 8,
   parameter int unsigned SW_W     = 8,
   parameter logic [31:0] BUILD_ID = 32'h0927_2011,
   parameter int unsigned CLK_HZ   = 10_000_000
) (
   input  bctl_sel_t         sel,
   input  logic [LED_W-1:0]  led,
   input  logic [SW_W-1:0]   sw,
   output logic [DATA_W-1:0] rd_val
);
   always_comb begin
      rd_val = '0;
      unique case (1'b1)
         sel.id:   rd_val = DATA_W'(BUILD_ID);
         sel.freq: rd_val = DATA_W'(CLK_HZ);
         sel.led:  rd_val = DATA_W'(led);
         sel.sw:   rd_val = DATA_W'(sw);
         default:  rd_val = '0;
      endcase
   end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
   import board_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LED_W       = 8,
   parameter int unsigned SW_W        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_HZ      = 10_000_000,
   parameter logic [31:0] BUILD_ID    = 32'h0927_2011,
   parameter logic [31:0] MAGIC       = 32'h0000_DEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [SW_W-1:0]   sw_i,
   output logic [LED_W-1:0]  led_o,
   output logic              board_rst_req
);
   generate
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_chk_addr
         $error("ADDR_W must cover the map and stay within 64 KiB");
      end
      if (DATA_W != 32) begin : g_chk_data
         $error("DATA_W must be 32");
      end
      if (LED_W < 1 || LED_W > DATA_W) begin : g_chk_led
         $error("LED_W out of range");
      end
      if (SW_W < 1 || SW_W > DATA_W) begin : g_chk_sw
         $error("SW_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   bctl_sel_t         sel;
   logic [SW_W-1:0]   sw_sync;
   logic [DATA_W-1:0] rd_val;

   bctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   bctl_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sw_i),
      .q     (sw_sync)
   );

   bctl_rst_gate #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_rgate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (bus_wr && sel.rst),
      .wdata  (bus_wdata),
      .req    (board_rst_req)
   );

   bctl_rdmux #(
      .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W),
      .BUILD_ID(BUILD_ID), .CLK_HZ(CLK_HZ)
   ) u_rmux (
      .sel    (sel),
      .led    (led_o),
      .sw     (sw_sync),
      .rd_val (rd_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 led_o <= '0;
      else if (bus_wr && sel.led) led_o <= bus_wdata[LED_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
      else             bus_rdata <= '0;
   end
endmodule

// File: rtl/bctl_checker.sv
module bctl_checker #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LED_W    = 8,
   parameter logic [31:0] BUILD_ID = 32'h0927_2011,
   parameter logic [31:0] MAGIC    = 32'h0000_DEAD
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [LED_W-1:0]  led_o,
   input logic              board_rst_req
);
   localparam int unsigned WW = ADDR_W - 2;

   logic at_id, at_led, at_rst;
   assign at_id  = (bus_addr[ADDR_W-1:2] == WW'(0));
   assign at_led = (bus_addr[ADDR_W-1:2] == WW'(2));
   assign at_rst = (bus_addr[ADDR_W-1:2] == WW'(4));

   AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_id) |=> (bus_rdata == DATA_W'(BUILD_ID))); // R1
   AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_led) |=> (led_o == $past(bus_wdata[LED_W-1:0]))); // R3
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && at_led) |=> $stable(led_o)); // R7
   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      board_rst_req |-> $past(bus_wr && at_rst && bus_wdata == DATA_W'(MAGIC))); // R5
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      board_rst_req |=> !board_rst_req); // R6
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R8
endmodule

bind board_ctl_regs bctl_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
   .BUILD_ID(BUILD_ID), .MAGIC(MAGIC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .bus_rd        (bus_rd),
   .bus_wr        (bus_wr),
   .bus_wdata     (bus_wdata),
   .bus_rdata     (bus_rdata),
   .led_o         (led_o),
   .board_rst_req (board_rst_req)
);

// File: tb/sim_board_ctl_regs.sv
`timescale 1ns/1ps
module sim_board_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  sw_i = '0;
   logic [7:0]  led_o;
   logic        board_rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   board_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sw_i(sw_i), .led_o(led_o), .board_rst_req(board_rst_req)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write strobe for one cycle; returns 1 ns after the write edge
   task automatic bwrite(logic [15:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   // read strobe for one cycle; result is valid after that edge
   task automatic bread(logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 led", 32'(led_o), 32'h0);
      chk("R10 rdata", bus_rdata, 32'h0);
      chk("R10 req", 32'(board_rst_req), 32'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_const();
      logic [31:0] v;
      bread(16'h0000, v); chk("R1 id", v, 32'h0927_2011);
      bread(16'h0004, v); chk("R2 freq", v, 32'h0098_9680);
      bwrite(16'h0000, 32'h1234_5678);
      bwrite(16'h0004, 32'h0);
      bread(16'h0000, v); chk("R1 id after write", v, 32'h0927_2011);
      bread(16'h0004, v); chk("R2 freq after write", v, 32'h0098_9680);
   endtask

   task automatic t_led();
      logic [31:0] v;
      bwrite(16'h0008, 32'hFFFF_FFA5);
      chk("R3 led out", 32'(led_o), 32'hA5);
      bread(16'h0008, v); chk("R3 led read", v, 32'h0000_00A5);
      bwrite(16'h0008, 32'h0000_003C);
      chk("R3 led out 2", 32'(led_o), 32'h3C);
      @(negedge clk);
      chk("R8 idle zero", bus_rdata, 32'h0);
   endtask

   task automatic t_switch();
      logic [31:0] v;
      @(negedge clk); sw_i = 8'h5A;
      repeat (2) @(posedge clk);
      bread(16'h000C, v); chk("R4 switches", v, 32'h0000_005A);
      @(negedge clk); sw_i = 8'hC3;
      bread(16'h000C, v); chk("R4 sync delay old", v, 32'h0000_005A);
   endtask

   task automatic t_magic();
      logic [31:0] v;
      bwrite(16'h0010, 32'h0000_DEAD);
      chk("R5 pulse", 32'(board_rst_req), 32'h1);
      @(posedge clk); #1;
      chk("R5 pulse ends", 32'(board_rst_req), 32'h0);
      bwrite(16'h0010, 32'h0001_DEAD);
      chk("R5 wrong value", 32'(board_rst_req), 32'h0);
      bwrite(16'h0010, 32'h0000_DEAE);
      chk("R5 wrong value 2", 32'(board_rst_req), 32'h0);
      bwrite(16'h0014, 32'h0000_DEAD);
      chk("R5 wrong offset", 32'(board_rst_req), 32'h0);
      bread(16'h0010, v); chk("R5 read zero", v, 32'h0);
      // back-to-back magic writes
      @(negedge clk);
      bus_addr = 16'h0010; bus_wdata = 32'h0000_DEAD; bus_wr = 1'b1;
      @(posedge clk); #1;
      chk("R6 first pulse", 32'(board_rst_req), 32'h1);
      @(posedge clk); #1;
      chk("R6 no second pulse", 32'(board_rst_req), 32'h0);
      bus_wr = 1'b0;
   endtask

   task automatic t_undecoded();
      logic [31:0] v;
      bwrite(16'h0008, 32'h0000_0066);
      bread(16'h0014, v); chk("R7 read 0x14", v, 32'h0);
      bread(16'hFFFC, v); chk("R7 read 0xFFFC", v, 32'h0);
      bwrite(16'h0018, 32'hFFFF_FFFF);
      bwrite(16'h0108, 32'hFFFF_FFFF);
      bwrite(16'h000C, 32'hFFFF_FFFF);
      chk("R7 led untouched", 32'(led_o), 32'h66);
   endtask

   task automatic t_alias();
      logic [31:0] v;
      bread(16'h000B, v); chk("R9 0x0B reads led", v, 32'h0000_0066);
      bread(16'h0003, v); chk("R9 0x03 reads id", v, 32'h0927_2011);
      bwrite(16'h0009, 32'h0000_0081);
      chk("R9 0x09 writes led", 32'(led_o), 32'h81);
   endtask

   task automatic t_collide();
      @(negedge clk);
      bus_addr = 16'h0008; bus_wdata = 32'h0000_0017;
      bus_rd = 1'b1; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_wr = 1'b0;
      chk("R11 read old", bus_rdata, 32'h0000_0081);
      chk("R11 write new", 32'(led_o), 32'h17);
   endtask

   initial begin
      t_reset();
      t_const();
      t_led();
      t_switch();
      t_magic();
      t_undecoded();
      t_alias();
      t_collide();
      t_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule